// File: doc/BRIEF.md
# Control Endpoint Receive Buffer Controller

This block sits behind the packet receiver of a device-side bus controller and owns the receive storage for the default control endpoint. OUT data bytes arrive already checked, framed by a packet-end strobe that carries an error flag. The block keeps packet after packet in one shared buffer and tells the CPU only when there is something worth unloading. That happens when the buffer has filled, when a packet shorter than the maximum packet size arrives, or when the status stage of a control write begins with bytes still waiting. A one-cycle interrupt pulse marks each rise of the ready flag.

The block also follows the control-transfer phase. It starts over on every SETUP packet. It raises a setup-end flag when the status stage opens before firmware has marked the data stage complete. It holds a stall that firmware requests and answers every later data or status token with STALL until the next SETUP. Firmware sees a byte-read port, a clear strobe for the ready flag, a data-end strobe and a setup-end clear strobe. Each handshake is reported on a two-bit code output.

Top module: `ep0_rxbuf_ctrl`

## Requirements
- R1: Bytes of accepted OUT packets are stored in arrival order. `byte_count` equals the number of stored bytes. Each `cpu_rd` pulse advances the read position, and `cpu_rdata` always shows the byte at the current read position.
- R2: At the end of an error-free accepted packet, if the store holds exactly BUF_BYTES bytes, `buf_rdy` is 1 from the following cycle.
- R3: At the end of an error-free accepted packet, if the packet has fewer than MAXP bytes (zero-length included), `buf_rdy` is 1 from the following cycle.
- R4: Full-size packets that leave the store below BUF_BYTES do not set `buf_rdy` and produce no `irq`.
- R5: An `in_token` pulse with a non-empty store sets `buf_rdy`. With an empty store it leaves `buf_rdy` at 0.
- R6: An `in_token` pulse while no `cpu_data_end` has been seen since the last SETUP sets `setup_end`. After `cpu_data_end`, `in_token` leaves `setup_end` at 0. `cpu_clr_setup_end` clears `setup_end`.
- R7: A `cpu_clr_rdy` pulse returns `buf_rdy` to 0 and empties the store (`byte_count` 0) from the next cycle.
- R8: `irq` is 1 for exactly one cycle, in the first cycle that `buf_rdy` reads 1 after having been 0.
- R9: One cycle after the end of an error-free packet, the block reports a handshake on `hs_valid` and `hs_code`. The code is ACK (2'b01) whenever no stall is held and the store is accepting, with no check against any declared transfer length. The code is NAK (2'b10) when `buf_rdy` was 1 at the start of the packet; the bytes of that packet are ignored and `byte_count` stays unchanged.
- R10: `cpu_clr_rdy` together with `cpu_stall_req` sets `stall_active`. While it is set, OUT packets are ignored and answered with STALL (2'b11), and `in_token` is answered with STALL.
- R11: `rx_setup` clears `buf_rdy`, `setup_end`, `stall_active` and the data-end mark, and empties the store, from the next cycle.
- R12: A packet that ends with `rx_err` produces no handshake (`hs_valid` stays 0). Its bytes are removed, so `byte_count` returns to its value before the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_setup | input | 1 | Pulse: a SETUP packet was received |
| rx_valid | input | 1 | OUT data byte valid |
| rx_data | input | DW | OUT data byte |
| rx_end | input | 1 | Pulse: end of an OUT data packet |
| rx_err | input | 1 | Qualifies `rx_end`: the packet was corrupt |
| in_token | input | 1 | Pulse: IN token of the status stage |
| cpu_rd | input | 1 | Pulse: advance the read position |
| cpu_rdata | output | DW | Byte at the read position |
| cpu_clr_rdy | input | 1 | Pulse: buffer unloaded, clear ready and empty |
| cpu_stall_req | input | 1 | With `cpu_clr_rdy`: request a stall |
| cpu_data_end | input | 1 | Pulse: firmware marks the data stage complete |
| cpu_clr_setup_end | input | 1 | Pulse: clear `setup_end` |
| buf_rdy | output | 1 | Buffer holds data for the CPU |
| setup_end | output | 1 | Status stage opened without data-end mark |
| stall_active | output | 1 | Stall is being returned |
| irq | output | 1 | Endpoint interrupt pulse |
| byte_count | output | CW | Bytes held in the store |
| hs_valid | output | 1 | Handshake report valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |

## Verification
The checker watches on every cycle: the interrupt pulse on each rise of the ready flag and its one-cycle width, the reset of every flag and of the fill count after SETUP, the effect of the clear strobe, the silence after a corrupt packet, the STALL answer while a stall is held, and the frozen fill count while the ready flag is held. It also checks that every rise of the ready flag follows a packet end or a status token. Only the bench scenarios show the ordering of the stored bytes and the exact fill count at which the flag rises. They also show the difference between full-size and short packets, the data-end and setup-end interplay at the status token, and the rollback of a corrupt packet among good ones.

// File: rtl/ep0rx_pkg.sv
package ep0rx_pkg;
   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_e;
endpackage

// File: rtl/ep0rx_store.sv
module ep0rx_store #(
   parameter int BUF_BYTES = 128,
   parameter int DW        = 8,
   localparam int AW       = $clog2(BUF_BYTES),
   localparam int CW       = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_byte,
   input  logic          commit,
   input  logic          rollback,
   input  logic          rd_en,
   output logic [DW-1:0] rd_byte,
   output logic [CW-1:0] fill,
   output logic [CW-1:0] pkt_len
);
   localparam logic [CW-1:0] CAP = CW'(BUF_BYTES);

   logic [DW-1:0] mem [BUF_BYTES];
   logic [CW-1:0] wr_ptr, rd_ptr, base;

   always_ff @(posedge clk) begin
      if (wr_en && wr_ptr < CAP && !clear) mem[wr_ptr[AW-1:0]] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         base   <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         base   <= '0;
      end else begin
         if (wr_en && wr_ptr < CAP) wr_ptr <= wr_ptr + 1'b1;
         if (commit)        base   <= wr_ptr;
         else if (rollback) wr_ptr <= base;
         if (rd_en && rd_ptr < wr_ptr) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assign rd_byte = mem[rd_ptr[AW-1:0]];
   assign fill    = wr_ptr;
   assign pkt_len = wr_ptr - base;
endmodule

// File: rtl/ep0rx_ctrl.sv
module ep0rx_ctrl
   import ep0rx_pkg::*;
#(
   parameter int BUF_BYTES = 128,
   parameter int MAXP      = 8,
   parameter bit IRQ_PULSE = 1'b1,
   localparam int CW       = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_setup,
   input  logic          rx_valid,
   input  logic          rx_end,
   input  logic          rx_err,
   input  logic          in_token,
   input  logic          cpu_clr_rdy,
   input  logic          cpu_stall_req,
   input  logic          cpu_data_end,
   input  logic          cpu_clr_setup_end,
   input  logic [CW-1:0] fill,
   input  logic [CW-1:0] pkt_len,
   output logic          wr_en,
   output logic          commit,
   output logic          rollback,
   output logic          store_clear,
   output logic          buf_rdy,
   output logic          setup_end,
   output logic          stall_active,
   output logic          irq,
   output logic          hs_valid,
   output hs_e           hs_code
);
   localparam logic [CW-1:0] CAP   = CW'(BUF_BYTES);
   localparam logic [CW-1:0] MAXPC = CW'(MAXP);

   logic in_pkt, drop_q, data_end, rise_q;
   logic drop_now, end_ok, set_rdy;

   always_comb begin
      drop_now    = in_pkt ? drop_q : (buf_rdy || stall_active);
      wr_en       = rx_valid && !drop_now && !rx_setup;
      end_ok      = rx_end && !rx_err && !drop_now && !rx_setup;
      commit      = end_ok;
      rollback    = rx_end && rx_err && !drop_now && !rx_setup;
      store_clear = rx_setup || cpu_clr_rdy;
      set_rdy     = (end_ok && (fill == CAP || pkt_len < MAXPC))
                 || (in_token && !stall_active && fill != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt       <= 1'b0;
         drop_q       <= 1'b0;
         data_end     <= 1'b0;
         buf_rdy      <= 1'b0;
         setup_end    <= 1'b0;
         stall_active <= 1'b0;
         rise_q       <= 1'b0;
         hs_valid     <= 1'b0;
         hs_code      <= HS_NONE;
      end else if (rx_setup) begin
         in_pkt       <= 1'b0;
         drop_q       <= 1'b0;
         data_end     <= 1'b0;
         buf_rdy      <= 1'b0;
         setup_end    <= 1'b0;
         stall_active <= 1'b0;
         rise_q       <= 1'b0;
         hs_valid     <= 1'b0;
         hs_code      <= HS_NONE;
      end else begin
         if (rx_end) in_pkt <= 1'b0;
         else if (rx_valid && !in_pkt) begin
            in_pkt <= 1'b1;
            drop_q <= buf_rdy || stall_active;
         end
         if (cpu_clr_rdy)  buf_rdy <= 1'b0;
         else if (set_rdy) buf_rdy <= 1'b1;
         rise_q <= set_rdy && !buf_rdy && !cpu_clr_rdy;
         if (cpu_clr_rdy && cpu_stall_req) stall_active <= 1'b1;
         if (cpu_data_end) data_end <= 1'b1;
         if (in_token && !data_end && !stall_active) setup_end <= 1'b1;
         else if (cpu_clr_setup_end)                 setup_end <= 1'b0;
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
         if (rx_end && !rx_err) begin
            hs_valid <= 1'b1;
            hs_code  <= stall_active ? HS_STALL : (drop_now ? HS_NAK : HS_ACK);
         end else if (in_token && stall_active) begin
            hs_valid <= 1'b1;
            hs_code  <= HS_STALL;
         end
      end
   end

   generate
      if (IRQ_PULSE) begin : g_irq_pulse
         assign irq = rise_q;
      end else begin : g_irq_level
         assign irq = buf_rdy;
      end
   endgenerate
endmodule

// File: rtl/ep0_rxbuf_ctrl.sv
module ep0_rxbuf_ctrl
   import ep0rx_pkg::*;
#(
   parameter int BUF_BYTES = 128,
   parameter int MAXP      = 8,
   parameter int DW        = 8,
   parameter bit IRQ_PULSE = 1'b1,
   localparam int CW       = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_setup,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_end,
   input  logic          rx_err,
   input  logic          in_token,
   input  logic          cpu_rd,
   output logic [DW-1:0] cpu_rdata,
   input  logic          cpu_clr_rdy,
   input  logic          cpu_stall_req,
   input  logic          cpu_data_end,
   input  logic          cpu_clr_setup_end,
   output logic          buf_rdy,
   output logic          setup_end,
   output logic          stall_active,
   output logic          irq,
   output logic [CW-1:0] byte_count,
   output logic          hs_valid,
   output logic [1:0]    hs_code
);
   generate
      if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES < 2) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two");
      end
      if (MAXP < 1 || MAXP > BUF_BYTES || (BUF_BYTES % MAXP) != 0) begin : g_bad_maxp
         $error("MAXP must divide BUF_BYTES");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic          wr_en, commit, rollback, store_clear;
   logic [CW-1:0] fill, pkt_len;
   hs_e           hs_int;

   ep0rx_store #(.BUF_BYTES(BUF_BYTES), .DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (store_clear),
      .wr_en    (wr_en),
      .wr_byte  (rx_data),
      .commit   (commit),
      .rollback (rollback),
      .rd_en    (cpu_rd),
      .rd_byte  (cpu_rdata),
      .fill     (fill),
      .pkt_len  (pkt_len)
   );

   ep0rx_ctrl #(.BUF_BYTES(BUF_BYTES), .MAXP(MAXP), .IRQ_PULSE(IRQ_PULSE)) u_ctrl (
      .clk               (clk),
      .rst_n             (rst_n),
      .rx_setup          (rx_setup),
      .rx_valid          (rx_valid),
      .rx_end            (rx_end),
      .rx_err            (rx_err),
      .in_token          (in_token),
      .cpu_clr_rdy       (cpu_clr_rdy),
      .cpu_stall_req     (cpu_stall_req),
      .cpu_data_end      (cpu_data_end),
      .cpu_clr_setup_end (cpu_clr_setup_end),
      .fill              (fill),
      .pkt_len           (pkt_len),
      .wr_en             (wr_en),
      .commit            (commit),
      .rollback          (rollback),
      .store_clear       (store_clear),
      .buf_rdy           (buf_rdy),
      .setup_end         (setup_end),
      .stall_active      (stall_active),
      .irq               (irq),
      .hs_valid          (hs_valid),
      .hs_code           (hs_int)
   );

   assign hs_code    = hs_int;
   assign byte_count = fill;
endmodule

// File: rtl/ep0rx_checker.sv
module ep0rx_checker #(
   parameter int BUF_BYTES = 128,
   parameter bit IRQ_PULSE = 1'b1,
   localparam int CW       = $clog2(BUF_BYTES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_setup,
   input logic          rx_end,
   input logic          rx_err,
   input logic          in_token,
   input logic          cpu_clr_rdy,
   input logic          buf_rdy,
   input logic          setup_end,
   input logic          stall_active,
   input logic          irq,
   input logic [CW-1:0] byte_count,
   input logic          hs_valid,
   input logic [1:0]    hs_code
);
   generate
      if (IRQ_PULSE) begin : g_pulse_chk
         a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(buf_rdy) |-> irq);
         a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            irq |=> !irq);
      end
   endgenerate

   a_r11_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_setup |=> (!buf_rdy && !setup_end && !stall_active && byte_count == '0));

   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clr_rdy && !rx_setup) |=> (!buf_rdy && byte_count == '0));

   a_r10_stall_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_active && rx_end && !rx_err && !rx_setup && !cpu_clr_rdy) |=> (hs_valid && hs_code == 2'b11));

   a_r12_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && rx_err && !rx_setup) |=> !hs_valid);

   a_r9_hold_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rdy && !cpu_clr_rdy && !rx_setup) |=> $stable(byte_count));

   a_r2_rdy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_rdy) |-> $past(rx_end || in_token));
endmodule

bind ep0_rxbuf_ctrl ep0rx_checker #(.BUF_BYTES(BUF_BYTES), .IRQ_PULSE(IRQ_PULSE)) u_chk (.*);

// File: tb/ep0_rxbuf_ctrl_test.sv
module ep0_rxbuf_ctrl_test;
   localparam int BUF = 128;
   localparam int MAXP = 8;
   localparam int CW = $clog2(BUF + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_setup = 0, rx_valid = 0, rx_end = 0, rx_err = 0, in_token = 0;
   logic [7:0] rx_data = '0;
   logic cpu_rd = 0, cpu_clr_rdy = 0, cpu_stall_req = 0, cpu_data_end = 0, cpu_clr_setup_end = 0;
   logic [7:0] cpu_rdata;
   logic buf_rdy, setup_end, stall_active, irq, hs_valid;
   logic [CW-1:0] byte_count;
   logic [1:0] hs_code;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [7:0] exp_mem [BUF];
   int exp_n = 0;
   logic [7:0] tag = 8'h10;
   logic cap_hs_valid, cap_irq;
   logic [1:0] cap_hs_code;

   always #2 clk = ~clk;

   ep0_rxbuf_ctrl uut (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic capture();
      cap_hs_valid = hs_valid;
      cap_hs_code  = hs_code;
      cap_irq      = irq;
   endtask

   task automatic pulse_setup();
      @(negedge clk) rx_setup = 1;
      @(negedge clk) rx_setup = 0;
      exp_n = 0;
   endtask

   task automatic send_pkt(int n, bit err, bit keep);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_data = tag;
         if (keep && !err) begin exp_mem[exp_n] = tag; exp_n++; end
         tag = tag + 8'd3;
      end
      @(negedge clk);
      rx_valid = 0; rx_end = 1; rx_err = err;
      @(negedge clk);
      rx_end = 0; rx_err = 0;
      capture();
   endtask

   task automatic send_token();
      @(negedge clk) in_token = 1;
      @(negedge clk) in_token = 0;
      capture();
   endtask

   task automatic cpu_clear(bit stall);
      @(negedge clk) begin cpu_clr_rdy = 1; cpu_stall_req = stall; end
      @(negedge clk) begin cpu_clr_rdy = 0; cpu_stall_req = 0; end
      exp_n = 0;
   endtask

   task automatic t_reset();
      chk("R11 reset buf_rdy", buf_rdy, 0);
      chk("R11 reset count", byte_count, 0);
      chk("R8 reset irq", irq, 0);
      chk("R9 reset hs_valid", hs_valid, 0);
      chk("R6 reset setup_end", setup_end, 0);
      chk("R10 reset stall", stall_active, 0);
   endtask

   task automatic t_short();
      pulse_setup();
      send_pkt(MAXP, 0, 1);
      chk("R9 ack full-size", {30'd0, cap_hs_code}, 1);
      chk("R4 no rdy after full-size", buf_rdy, 0);
      chk("R1 count after 8", byte_count, 8);
      send_pkt(3, 0, 1);
      chk("R3 short sets rdy", buf_rdy, 1);
      chk("R8 irq on rise", cap_irq, 1);
      @(negedge clk);
      chk("R8 irq one cycle", irq, 0);
      chk("R1 count after short", byte_count, 11);
      for (int i = 0; i < 11; i++) begin
         chk("R1 read order", cpu_rdata, exp_mem[i]);
         cpu_rd = 1;
         @(negedge clk) cpu_rd = 0;
      end
      cpu_clear(0);
      chk("R7 clear rdy", buf_rdy, 0);
      chk("R7 clear count", byte_count, 0);
      send_pkt(0, 0, 1);
      chk("R3 zero-length sets rdy", buf_rdy, 1);
      cpu_clear(0);
   endtask

   task automatic t_full_nak();
      bit seen_irq = 0;
      pulse_setup();
      for (int p = 0; p < BUF / MAXP - 1; p++) begin
         send_pkt(MAXP, 0, 1);
         if (cap_irq || buf_rdy) seen_irq = 1;
      end
      chk("R4 no irq below capacity", seen_irq, 0);
      chk("R4 count below capacity", byte_count, BUF - MAXP);
      send_pkt(MAXP, 0, 1);
      chk("R2 full sets rdy", buf_rdy, 1);
      chk("R2 full count", byte_count, BUF);
      chk("R8 irq on full", cap_irq, 1);
      send_pkt(MAXP, 0, 0);
      chk("R9 nak while ready", {30'd0, cap_hs_code}, 2);
      chk("R9 nak bytes ignored", byte_count, BUF);
      chk("R1 first byte kept", cpu_rdata, exp_mem[0]);
      cpu_clear(0);
   endtask

   task automatic t_status();
      pulse_setup();
      for (int p = 0; p < 8; p++) send_pkt(MAXP, 0, 1);
      chk("R4 burst of full-size no rdy", buf_rdy, 0);
      send_token();
      chk("R5 token with pending sets rdy", buf_rdy, 1);
      chk("R6 token without data-end", setup_end, 1);
      chk("R8 irq on status", cap_irq, 1);
      @(negedge clk) cpu_clr_setup_end = 1;
      @(negedge clk) cpu_clr_setup_end = 0;
      chk("R6 clear setup_end", setup_end, 0);
      cpu_clear(0);
      pulse_setup();
      send_pkt(MAXP, 0, 1);
      @(negedge clk) cpu_data_end = 1;
      @(negedge clk) cpu_data_end = 0;
      send_token();
      chk("R5 token after data-end rdy", buf_rdy, 1);
      chk("R6 data-end keeps setup_end low", setup_end, 0);
      cpu_clear(0);
      pulse_setup();
      send_token();
      chk("R5 token on empty no rdy", buf_rdy, 0);
      chk("R6 token on empty setup_end", setup_end, 1);
   endtask

   task automatic t_err();
      pulse_setup();
      send_pkt(MAXP, 0, 1);
      send_pkt(5, 1, 1);
      chk("R12 no handshake on error", cap_hs_valid, 0);
      chk("R12 rollback count", byte_count, 8);
      send_pkt(2, 0, 1);
      chk("R12 count after good short", byte_count, 10);
      for (int i = 0; i < 10; i++) begin
         chk("R12 data after rollback", cpu_rdata, exp_mem[i]);
         cpu_rd = 1;
         @(negedge clk) cpu_rd = 0;
      end
      cpu_clear(0);
   endtask

   task automatic t_stall();
      pulse_setup();
      send_pkt(MAXP, 0, 1);
      cpu_clear(1);
      chk("R10 stall set", stall_active, 1);
      send_pkt(MAXP, 0, 0);
      chk("R10 out answered stall", {30'd0, cap_hs_code}, 3);
      chk("R10 out bytes ignored", byte_count, 0);
      send_token();
      chk("R10 token answered stall", {31'd0, cap_hs_valid}, 1);
      chk("R10 token stall code", {30'd0, cap_hs_code}, 3);
      pulse_setup();
      chk("R11 setup clears stall", stall_active, 0);
      chk("R11 setup clears setup_end", setup_end, 0);
      send_pkt(MAXP, 0, 1);
      chk("R9 ack after setup", {30'd0, cap_hs_code}, 1);
      chk("R11 fresh count", byte_count, 8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_short();
      t_full_nak();
      t_status();
      t_err();
      t_stall();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule